// File: doc/BRIEF.md
# Inter-Frame Gap Timer

This block holds off the next transmission after a frame ends. The transmit path pulses an end-of-frame strobe, and the block then measures the idle gap in bit times at the current link rate: 10, 100 or 1000 Mb/s. It runs from one fixed 125 MHz reference clock. When the gap has elapsed, it raises a ready flag, and the transmit path may start the next frame.

The gap is 96 bit times plus an extension. A 3-bit gap code selects the extension, and the encoding is not sequential. The extension is counted in bit times, so it scales with the link rate in the same way as the base gap. Each clock, the block adds the link rate in Mb/s to an accumulator. It compares the sum against the gap length times the clock frequency in MHz. This gives every setting an exact cycle count. The 100 Mb/s and 10 Mb/s rates need fractional bit times per clock, and this method handles them without rounding.

Top module: `ifg_timer`

## Requirements
- R1: `tx_ready` is 1 while `rst` is high and in the first cycle after `rst` falls.
- R2: A `tx_eof` pulse sampled at a clock edge drives `tx_ready` to 0 from that edge onward.
- R3: With `link_speed` = 2'b10 (1000 Mb/s), `tx_ready` stays low for the number of cycles that the gap code selects, then rises: 3'b011 gives 12 cycles (96 bit times), 3'b101 gives 13 (104), 3'b111 gives 14 (112), 3'b001 gives 15 (120) and 3'b010 gives 18 (144).
- R4: With `link_speed` = 2'b01 (100 Mb/s), the same codes give 120, 130, 140, 150 and 180 low cycles.
- R5: With `link_speed` = 2'b00 (10 Mb/s), the same codes give 1200, 1300, 1400, 1500 and 1800 low cycles.
- R6: Gap codes 3'b000, 3'b100 and 3'b110 are reserved and act as 96 bit times (3'b011).
- R7: Gap code and link speed are sampled only with `tx_eof`. Changes to them while a gap runs do not alter that gap's length.
- R8: A `tx_eof` pulse during a running gap restarts the full gap from that pulse.
- R9: Once high, `tx_ready` stays high until the next `tx_eof`.
- R10: `link_speed` = 2'b11 is treated as 1000 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_eof | input | 1 | One-cycle end-of-frame strobe from the transmit path |
| gap_code | input | 3 | Gap extension selector |
| link_speed | input | 2 | 00: 10 Mb/s, 01: 100 Mb/s, 10 or 11: 1000 Mb/s |
| tx_ready | output | 1 | High when the gap has elapsed and the next frame may start |

## Verification
The bench builds the block with its default values: a 125 MHz reference, a 96-bit base gap and rates of 10, 100 and 1000 Mb/s. With these values, every gap is a whole number of clocks between 12 and 1800. The bench can therefore count the low cycles of every gap exactly. This includes the longest 10 Mb/s gap, and it makes an error of a single cycle in the accumulator compare visible. With the small 1000 Mb/s gaps, a restart and an input change can land in the middle of a gap within a few cycles.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_ALT  = 2'b11
  } link_speed_e;

  localparam int EXT_MAX_BITS = 48;

  // Extension in bit times added to the base gap; reserved codes add nothing.
  function automatic int gap_ext_bits(input logic [2:0] code);
    case (code)
      3'b011:  return 0;
      3'b101:  return 8;
      3'b111:  return 16;
      3'b001:  return 24;
      3'b010:  return EXT_MAX_BITS;
      default: return 0;
    endcase
  endfunction

  // Link rate in Mb/s for a speed selector.
  function automatic int rate_mbps(input logic [1:0] spd, input int lo, input int mid, input int hi);
    case (spd)
      SPD_10:  return lo;
      SPD_100: return mid;
      default: return hi;
    endcase
  endfunction

endpackage

// File: rtl/ifg_gap_decode.sv
module ifg_gap_decode #(
  parameter int BASE_BITS = 96,
  parameter int REF_MHZ   = 125,
  parameter int TGT_W     = 15
) (
  input  logic [2:0]       gap_code,
  output logic [TGT_W-1:0] target
);
  // Gap length in units of bit-times x MHz.
  assign target = TGT_W'((BASE_BITS + ifg_pkg::gap_ext_bits(gap_code)) * REF_MHZ);
endmodule

// File: rtl/ifg_rate_step.sv
module ifg_rate_step #(
  parameter int RATE_LO  = 10,
  parameter int RATE_MID = 100,
  parameter int RATE_HI  = 1000,
  parameter int STEP_W   = 10
) (
  input  logic [1:0]        link_speed,
  output logic [STEP_W-1:0] step
);
  assign step = STEP_W'(ifg_pkg::rate_mbps(link_speed, RATE_LO, RATE_MID, RATE_HI));
endmodule

// File: rtl/ifg_gap_count.sv
module ifg_gap_count #(
  parameter int ACC_W  = 15,
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gap_start,
  input  logic [ACC_W-1:0]  target_in,
  input  logic [STEP_W-1:0] step_in,
  output logic              ready,
  output logic              gap_done,
  output logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  target_q,
  output logic [STEP_W-1:0] step_q
);
  logic [ACC_W-1:0] acc_next;

  assign acc_next = acc_q + ACC_W'(step_q);
  assign gap_done = !ready && !gap_start && (acc_next >= target_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      acc_q    <= '0;
      target_q <= '0;
      step_q   <= '0;
    end else if (gap_start) begin
      ready    <= 1'b0;
      acc_q    <= '0;
      target_q <= target_in;
      step_q   <= step_in;
    end else if (!ready) begin
      acc_q <= acc_next;
      if (gap_done) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/ifg_timer.sv
module ifg_timer #(
  parameter int REF_MHZ   = 125,
  parameter int BASE_BITS = 96,
  parameter int RATE_LO   = 10,
  parameter int RATE_MID  = 100,
  parameter int RATE_HI   = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_eof,
  input  logic [2:0] gap_code,
  input  logic [1:0] link_speed,
  output logic       tx_ready
);
  localparam int MAX_TARGET = (BASE_BITS + ifg_pkg::EXT_MAX_BITS) * REF_MHZ;
  localparam int STEP_W     = $clog2(RATE_HI + 1);
  localparam int ACC_W      = $clog2(MAX_TARGET + RATE_HI + 1);

  logic              gap_start;
  logic              gap_done;
  logic [ACC_W-1:0]  target_now;
  logic [STEP_W-1:0] step_now;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  target_q;
  logic [STEP_W-1:0] step_q;

  assign gap_start = tx_eof;

  ifg_gap_decode #(.BASE_BITS(BASE_BITS), .REF_MHZ(REF_MHZ), .TGT_W(ACC_W)) u_decode (
    .gap_code (gap_code),
    .target   (target_now)
  );

  ifg_rate_step #(.RATE_LO(RATE_LO), .RATE_MID(RATE_MID), .RATE_HI(RATE_HI), .STEP_W(STEP_W)) u_step (
    .link_speed (link_speed),
    .step       (step_now)
  );

  ifg_gap_count #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .gap_start (gap_start),
    .target_in (target_now),
    .step_in   (step_now),
    .ready     (tx_ready),
    .gap_done  (gap_done),
    .acc_q     (acc_q),
    .target_q  (target_q),
    .step_q    (step_q)
  );
endmodule

// File: rtl/ifg_timer_chk.sv
module ifg_timer_chk #(
  parameter int ACC_W  = 15,
  parameter int STEP_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_eof,
  input logic              tx_ready,
  input logic              gap_done,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ACC_W-1:0]  target_q,
  input logic [STEP_W-1:0] step_q
);
  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> tx_ready);

  // R2
  eof_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    tx_eof |=> !tx_ready);

  // R9
  ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready && !tx_eof |=> tx_ready);

  // R7
  settings_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_ready && !tx_eof |=> $stable(target_q) && $stable(step_q));

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    tx_eof |=> acc_q == '0);

  // R3
  done_raises_chk: assert property (@(posedge clk) disable iff (rst)
    gap_done |=> tx_ready);

  // R3
  no_early_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_ready && !tx_eof && !gap_done |=> !tx_ready);

  // R4
  rise_at_target_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> acc_q >= target_q);
endmodule

bind ifg_timer ifg_timer_chk #(.ACC_W(ACC_W), .STEP_W(STEP_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_eof   (tx_eof),
  .tx_ready (tx_ready),
  .gap_done (gap_done),
  .acc_q    (acc_q),
  .target_q (target_q),
  .step_q   (step_q)
);

// File: tb/test_ifg_timer.sv
module test_ifg_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_eof = 1'b0;
  logic [2:0] gap_code = 3'b011;
  logic [1:0] link_speed = 2'b10;
  wire        tx_ready;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ifg_timer i_ifg_timer (
    .clk        (clk),
    .rst        (rst),
    .tx_eof     (tx_eof),
    .gap_code   (gap_code),
    .link_speed (link_speed),
    .tx_ready   (tx_ready)
  );

  // {speed[1:0], code[2:0], expected low cycles[11:0]}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {2'b10, 3'b011, 12'd12},   {2'b10, 3'b101, 12'd13},   {2'b10, 3'b111, 12'd14},
    {2'b10, 3'b001, 12'd15},   {2'b10, 3'b010, 12'd18},   {2'b10, 3'b000, 12'd12},
    {2'b10, 3'b100, 12'd12},   {2'b10, 3'b110, 12'd12},   {2'b01, 3'b011, 12'd120},
    {2'b01, 3'b101, 12'd130},  {2'b01, 3'b111, 12'd140},  {2'b01, 3'b001, 12'd150},
    {2'b01, 3'b010, 12'd180},  {2'b01, 3'b110, 12'd120},  {2'b00, 3'b011, 12'd1200},
    {2'b00, 3'b010, 12'd1800}, {2'b11, 3'b001, 12'd15}
  };

  function automatic string row_tag(input logic [1:0] spd, input logic [2:0] code);
    if (code == 3'b000 || code == 3'b100 || code == 3'b110) return "R6";
    if (spd == 2'b11) return "R10";
    if (spd == 2'b10) return "R3";
    if (spd == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_gap(input logic [1:0] spd, input logic [2:0] code);
    @(negedge clk);
    link_speed = spd;
    gap_code   = code;
    tx_eof     = 1'b1;
    @(negedge clk);
    tx_eof = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!tx_ready && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: ready during and just after reset
    repeat (3) @(negedge clk);
    check(tx_ready == 1'b1, "R1", tx_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1", tx_ready, 1);

    for (int i = 0; i < NV; i++) begin
      start_gap(VEC[i][16:15], VEC[i][14:12]);
      check(tx_ready == 1'b0, "R2", tx_ready, 0);
      count_low(n);
      check(n == int'(VEC[i][11:0]), row_tag(VEC[i][16:15], VEC[i][14:12]), n, int'(VEC[i][11:0]));
    end

    // R9: ready stays up with no strobe
    repeat (25) @(negedge clk);
    check(tx_ready == 1'b1, "R9", tx_ready, 1);

    // R7: changing settings mid-gap leaves the running gap at 12 cycles
    start_gap(2'b10, 3'b011);
    link_speed = 2'b00;
    gap_code   = 3'b010;
    count_low(n);
    check(n == 12, "R7", n, 12);

    // R8: second strobe in the middle restarts the full 18-cycle gap
    start_gap(2'b10, 3'b010);
    repeat (5) @(negedge clk);
    check(tx_ready == 1'b0, "R8", tx_ready, 0);
    start_gap(2'b10, 3'b010);
    count_low(n);
    check(n == 18, "R8", n, 18);

    // R5: a mid-range 10 Mb/s code
    start_gap(2'b00, 3'b001);
    count_low(n);
    check(n == 1500, "R5", n, 1500);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule